// File: doc/BRIEF.md
# Serial Control Register Port

This block is the write-only control port of an audio converter. A host writes 16-bit frames over three wires: an active-low select (`csN`), a serial clock (`sclk`) and a data line (`sdi`). The block oversamples all three with the core clock `clk`, shifts the frame in, and checks the chip address and the write bit. When the select line returns high it commits the 8-bit payload to one of three small control registers.

The registers drive the converter's configuration fields as separate outputs: master-clock ratio, input format, run/reset bit, zero-detect enable and mode, filter roll-off, sampling speed, de-emphasis, soft mute and output gain. The power-down input `pdN` is active low and asynchronous. It returns every register to its default value and holds the serial port in reset while it is low. A few fields may also be set from board pins. In serial mode the pin and the register bit are ORed. In pin mode the pin alone sets those fields.

Top module: `ctrl_port_top`

## Requirements
- R1: While `pdN` is low and after it is released, register 0 reads 01h (run bit 1, all other fields 0), register 1 reads 00h and the gain field reads 00.
- R2: A frame is 16 `sdi` bits sampled on rising `sclk` edges while `csN` is low, most significant bit first, in this order: a 2-bit chip address, the write bit, a 5-bit register address, then 8 data bits. The write takes effect after `csN` rises.
- R3: Register 0 (address 00h) maps data bit 0 to `outRun`, bits 3..1 to `outDif[2:0]` and bits 6..4 to `outCks[2:0]`. Data bit 7 is dropped.
- R4: Register 1 (address 01h) maps data bit 0 to `outMute`, bits 2..1 to `outDem[1:0]`, bits 4..3 to `outDfs[1:0]`, bit 5 to `outSlow`, bit 6 to `outZeroAnd` and bit 7 to `outZeroEn`.
- R5: Register 2 (address 02h) keeps only data bits 7..6, which drive `outGain[1:0]`. Bits 5..0 are dropped.
- R6: A frame addressed to 03h through 1Fh changes no output.
- R7: A frame whose chip address is not binary 01, or whose write bit is 0, changes no output.
- R8: A frame with other than exactly 16 rising `sclk` edges while `csN` is low changes no output.
- R9: A frame sent while `pdN` is low has no effect, and outputs stay at the R1 defaults after release.
- R10: Clearing the run bit through register 0 leaves the contents of registers 1 and 2 unchanged.
- R11: With `serialMode` high, `outDif`, `outCks[1]` and `outDfs[0]` are the OR of the register bit and `pinDif`, `pinCks1` and `pinDfs0` respectively. With `serialMode` low, these fields equal the pin alone.
- R12: No output changes before `csN` rises, even after all 16 bits have been clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the serial lines |
| pdN | input | 1 | Power-down, active low, asynchronous; restores defaults |
| serialMode | input | 1 | High: pins OR with register bits; low: pins alone |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial bit clock, idle high |
| sdi | input | 1 | Serial data in |
| pinDif | input | 3 | Input-format pins |
| pinCks1 | input | 1 | Clock-ratio middle bit pin |
| pinDfs0 | input | 1 | Speed low bit pin |
| outCks | output | 3 | Master clock ratio select |
| outDif | output | 3 | Audio input format select |
| outRun | output | 1 | Run (1) / internal timing reset (0) |
| outZeroEn | output | 1 | Zero-detect enable |
| outZeroAnd | output | 1 | Zero-detect both-channel mode |
| outSlow | output | 1 | Slow roll-off filter select |
| outDfs | output | 2 | Sampling speed select |
| outDem | output | 2 | De-emphasis select |
| outMute | output | 1 | Soft mute request |
| outGain | output | 2 | Output gain code |

## Verification
The bench targets frames with 15 and 17 clocks. A port that counted only up to 16, or that did not clear its count at select, would accept these frames and load a register from shifted bits. It also sends every illegal chip address and a write bit of 0, and frames to 03h and 1Fh. A loose address decode would alias these onto registers 0 to 2 and corrupt them. It holds the select low past the sixteenth bit, so an early commit shows on the outputs. It sends a frame during power-down and toggles the pins in both modes, where a missing reset gate or a wrong OR mask shows up directly at the outputs.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;

  typedef struct packed {
    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wrStrobe_t;
endpackage

// File: rtl/ctrl_port_serial.sv
module ctrl_port_serial
  import ctrl_port_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] CHIP_ID     = 2'b01
) (
  input  logic      clk,
  input  logic      pdN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  output wrStrobe_t wrStb
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] csSync, clkSync, datSync;
  logic                   sclkPrev, csPrev;
  logic [FRAME_W-1:0]     shiftQ;
  logic [CNT_W-1:0]       cntQ;
  logic                   sclkRise, csRise, csLow, frameOk;

  // oversample the three wires; idle level of select and clock is high
  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      csSync   <= '1;
      clkSync  <= '1;
      datSync  <= '0;
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
    end else begin
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      clkSync  <= {clkSync[SYNC_STAGES-2:0], sclk};
      datSync  <= {datSync[SYNC_STAGES-2:0], sdi};
      sclkPrev <= clkSync[SYNC_STAGES-1];
      csPrev   <= csSync[SYNC_STAGES-1];
    end
  end

  assign sclkRise = clkSync[SYNC_STAGES-1] & ~sclkPrev;
  assign csRise   = csSync[SYNC_STAGES-1] & ~csPrev;
  assign csLow    = ~csSync[SYNC_STAGES-1];

  // shift register and saturating bit counter, cleared while deselected
  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      shiftQ <= '0;
      cntQ   <= '0;
    end else if (csLow) begin
      if (sclkRise) begin
        shiftQ <= {shiftQ[FRAME_W-2:0], datSync[SYNC_STAGES-1]};
        if (cntQ != CNT_W'(CNT_MAX)) cntQ <= cntQ + 1'b1;
      end
    end else if (!csRise) begin
      cntQ <= '0;
    end
  end

  assign frameOk = (cntQ == CNT_W'(FRAME_W))
                 && (shiftQ[FRAME_W-1 -: 2] == CHIP_ID)
                 && shiftQ[FRAME_W-3];

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      wrStb <= '0;
    end else begin
      wrStb.commit <= csRise & frameOk;
      wrStb.addr   <= shiftQ[DATA_W +: ADDR_W];
      wrStb.data   <= shiftQ[DATA_W-1:0];
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!pdN)
    wrStb.commit |=> !wrStb.commit);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!pdN)
    cntQ <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/ctrl_port_regs.sv
module ctrl_port_regs
  import ctrl_port_pkg::*;
(
  input  logic       clk,
  input  logic       pdN,
  input  logic       serialMode,
  input  wrStrobe_t  wrStb,
  input  logic [2:0] pinDif,
  input  logic       pinCks1,
  input  logic       pinDfs0,
  output logic [2:0] outCks,
  output logic [2:0] outDif,
  output logic       outRun,
  output logic       outZeroEn,
  output logic       outZeroAnd,
  output logic       outSlow,
  output logic [1:0] outDfs,
  output logic [1:0] outDem,
  output logic       outMute,
  output logic [1:0] outGain
);
  localparam logic [6:0]        MODE_DEF = 7'h01;
  localparam logic [DATA_W-1:0] FEAT_DEF = '0;
  localparam logic [1:0]        GAIN_DEF = 2'b00;

  logic [6:0]        modeQ;
  logic [DATA_W-1:0] featQ;
  logic [1:0]        gainQ;

  always_ff @(posedge clk or negedge pdN) begin
    if (!pdN) begin
      modeQ <= MODE_DEF;
      featQ <= FEAT_DEF;
      gainQ <= GAIN_DEF;
    end else if (wrStb.commit) begin
      unique case (wrStb.addr)
        ADDR_W'(0): modeQ <= wrStb.data[6:0];
        ADDR_W'(1): featQ <= wrStb.data;
        ADDR_W'(2): gainQ <= wrStb.data[7:6];
        default: ;
      endcase
    end
  end

  assign outRun     = modeQ[0];
  assign outDif     = serialMode ? (modeQ[3:1] | pinDif) : pinDif;
  assign outCks     = {modeQ[6], serialMode ? (modeQ[5] | pinCks1) : pinCks1, modeQ[4]};
  assign outMute    = featQ[0];
  assign outDem     = featQ[2:1];
  assign outDfs     = {featQ[4], serialMode ? (featQ[3] | pinDfs0) : pinDfs0};
  assign outSlow    = featQ[5];
  assign outZeroAnd = featQ[6];
  assign outZeroEn  = featQ[7];
  assign outGain    = gainQ;

  p_hold_no_commit_r12: assert property (@(posedge clk) disable iff (!pdN)
    !$past(wrStb.commit) |-> $stable({modeQ, featQ, gainQ}));

  p_high_addr_r6: assert property (@(posedge clk) disable iff (!pdN)
    $past(wrStb.commit && (wrStb.addr > ADDR_W'(2))) |-> $stable({modeQ, featQ, gainQ}));
endmodule

// File: rtl/ctrl_port_top.sv
module ctrl_port_top
  import ctrl_port_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] CHIP_ID     = 2'b01
) (
  input  logic       clk,
  input  logic       pdN,
  input  logic       serialMode,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [2:0] pinDif,
  input  logic       pinCks1,
  input  logic       pinDfs0,
  output logic [2:0] outCks,
  output logic [2:0] outDif,
  output logic       outRun,
  output logic       outZeroEn,
  output logic       outZeroAnd,
  output logic       outSlow,
  output logic [1:0] outDfs,
  output logic [1:0] outDem,
  output logic       outMute,
  output logic [1:0] outGain
);
  wrStrobe_t wrStb;

  ctrl_port_serial #(.SYNC_STAGES(SYNC_STAGES), .CHIP_ID(CHIP_ID)) serial_i (
    .clk(clk), .pdN(pdN), .csN(csN), .sclk(sclk), .sdi(sdi), .wrStb(wrStb)
  );

  ctrl_port_regs regs_i (
    .clk(clk), .pdN(pdN), .serialMode(serialMode), .wrStb(wrStb),
    .pinDif(pinDif), .pinCks1(pinCks1), .pinDfs0(pinDfs0),
    .outCks(outCks), .outDif(outDif), .outRun(outRun),
    .outZeroEn(outZeroEn), .outZeroAnd(outZeroAnd), .outSlow(outSlow),
    .outDfs(outDfs), .outDem(outDem), .outMute(outMute), .outGain(outGain)
  );

  p_pin_only_r11: assert property (@(posedge clk) disable iff (!pdN)
    !serialMode |-> (outDif == pinDif && outCks[1] == pinCks1 && outDfs[0] == pinDfs0));
endmodule

// File: tb/ctrl_port_top_tb_top.sv
module ctrl_port_top_tb_top;
  logic clk = 1'b0;
  logic pdN = 1'b0, serialMode = 1'b1;
  logic csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [2:0] pinDif = 3'b000;
  logic pinCks1 = 1'b0, pinDfs0 = 1'b0;
  logic [2:0] outCks, outDif;
  logic outRun, outZeroEn, outZeroAnd, outSlow, outMute;
  logic [1:0] outDfs, outDem, outGain;

  int checks = 0, failures = 0;
  logic [7:0] m0 = 8'h01, m1 = 8'h00;
  logic [1:0] m2 = 2'b00;

  always #5 clk = ~clk;

  ctrl_port_top dut_i (
    .clk(clk), .pdN(pdN), .serialMode(serialMode), .csN(csN), .sclk(sclk), .sdi(sdi),
    .pinDif(pinDif), .pinCks1(pinCks1), .pinDfs0(pinDfs0),
    .outCks(outCks), .outDif(outDif), .outRun(outRun), .outZeroEn(outZeroEn),
    .outZeroAnd(outZeroAnd), .outSlow(outSlow), .outDfs(outDfs), .outDem(outDem),
    .outMute(outMute), .outGain(outGain)
  );

  function automatic logic [16:0] expVec();
    logic [2:0] d;
    logic [2:0] c;
    logic [1:0] f;
    d = serialMode ? (m0[3:1] | pinDif) : pinDif;
    c = {m0[6], serialMode ? (m0[5] | pinCks1) : pinCks1, m0[4]};
    f = {m1[4], serialMode ? (m1[3] | pinDfs0) : pinDfs0};
    return {m2, m1[7], m1[6], m1[5], f, m1[2:1], m1[0], c, d, m0[0]};
  endfunction

  function automatic logic [15:0] mk(logic [1:0] chip, logic wr, logic [4:0] addr, logic [7:0] data);
    return {chip, wr, addr, data};
  endfunction

  task automatic check(string tag);
    logic [16:0] act, ex;
    @(negedge clk);
    act = {outGain, outZeroEn, outZeroAnd, outSlow, outDfs, outDem, outMute, outCks, outDif, outRun};
    ex = expVec();
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, ex);
    end
  endtask

  task automatic applyModel(logic [31:0] word, int nbits);
    logic [15:0] fr;
    fr = word[15:0];
    if (!pdN || nbits != 16 || fr[15:14] != 2'b01 || !fr[13]) return;
    case (fr[12:8])
      5'd0: m0 = {1'b0, fr[6:0]};
      5'd1: m1 = fr[7:0];
      5'd2: m2 = fr[7:6];
      default: ;
    endcase
  endtask

  task automatic clockBits(logic [31:0] word, int nbits);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b0; sdi = word[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic sendFrame(logic [31:0] word, int nbits);
    clockBits(word, nbits);
    csN = 1'b1;
    repeat (8) @(negedge clk);
    applyModel(word, nbits);
  endtask

  string tag;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    check("R1 in power-down");
    pdN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");

    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd0, 8'h7E)}, 16); check("R3 all fields");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd0, 8'hA5)}, 16); check("R3 bit7 dropped");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'hFF)}, 16); check("R4 all ones");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'h5A)}, 16); check("R4 pattern");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd2, 8'hBF)}, 16); check("R5 gain");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd3, 8'h00)}, 16); check("R6 addr 03");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd31, 8'h00)}, 16); check("R6 addr 1F");
    sendFrame({16'h0, mk(2'b00, 1'b1, 5'd1, 8'h00)}, 16); check("R7 chip 00");
    sendFrame({16'h0, mk(2'b11, 1'b1, 5'd1, 8'h00)}, 16); check("R7 chip 11");
    sendFrame({16'h0, mk(2'b10, 1'b1, 5'd1, 8'h00)}, 16); check("R7 chip 10");
    sendFrame({16'h0, mk(2'b01, 1'b0, 5'd1, 8'h00)}, 16); check("R7 write bit 0");
    sendFrame({17'h0, mk(2'b01, 1'b1, 5'd1, 8'h00)}, 15); check("R8 15 clocks");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'h00)}, 17); check("R8 17 clocks");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'h3C)}, 16);
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd0, 8'h30)}, 16); check("R10 run cleared");

    clockBits({16'h0, mk(2'b01, 1'b1, 5'd1, 8'hC3)}, 16);
    repeat (8) @(negedge clk);
    check("R12 select still low");
    csN = 1'b1;
    repeat (8) @(negedge clk);
    applyModel({16'h0, mk(2'b01, 1'b1, 5'd1, 8'hC3)}, 16);
    check("R2 commit on select rise");

    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd0, 8'h00)}, 16);
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'h00)}, 16);
    pinDif = 3'b101; pinCks1 = 1'b1; pinDfs0 = 1'b1;
    check("R11 serial OR pins");
    serialMode = 1'b0; check("R11 pin mode");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd0, 8'h2A)}, 16);
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'h08)}, 16);
    pinDif = 3'b000; pinCks1 = 1'b0; pinDfs0 = 1'b0;
    check("R11 pin mode hides register");
    serialMode = 1'b1; check("R11 serial mode shows register");

    pdN = 1'b0; m0 = 8'h01; m1 = 8'h00; m2 = 2'b00;
    repeat (2) @(negedge clk);
    check("R1 power-down restores");
    sendFrame({16'h0, mk(2'b01, 1'b1, 5'd1, 8'hFF)}, 16);
    pdN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 write during power-down ignored");

    for (int n = 0; n < 60; n++) begin
      logic [1:0] chip;
      logic wr;
      logic [4:0] addr;
      int nb;
      logic [31:0] w;
      chip = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      wr   = ($urandom % 6 != 0);
      addr = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 3);
      nb   = ($urandom % 8 == 0) ? 15 + 2 * ($urandom % 2) : 16;
      w    = {16'($urandom), mk(chip, wr, addr, 8'($urandom))};
      pinDif = 3'($urandom); pinCks1 = 1'($urandom); pinDfs0 = 1'($urandom);
      serialMode = ($urandom % 4 != 0);
      sendFrame(w, nb);
      if (nb != 16) tag = "R8 random";
      else if (chip != 2'b01 || !wr) tag = "R7 random";
      else if (addr == 5'd0) tag = "R3 random";
      else if (addr == 5'd1) tag = "R4 random";
      else if (addr == 5'd2) tag = "R5 random";
      else tag = "R6 random";
      check(tag);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule